// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt lines, remembers which ones have fired, and turns them into one request line for a processor. Software reaches it through eight word-addressed registers. A per-input enable masks the latched status. A two-bit master control gates the final request. A vector register gives the number of the lowest-numbered input that is both latched and enabled, so a handler can dispatch with a single read.

A build-time mask sets each input to be edge-sensitive or level-sensitive. An edge input latches on a rising transition and stays latched until software clears it. A level input latches whenever its line is high, so clearing it has no effect while the line is still asserted. Enable bits can be changed one at a time, without a read-modify-write, through separate set and clear aliases. Latched bits are cleared by writing ones to the acknowledge location.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Register offsets are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. Offsets 3, 4 and 5 read as zero. Writes to offsets 0, 1 and 6 change no state.
- R2: A write to offset 2 replaces the whole enable register. Writing zero there masks every input, and `irq_o` stays low until an enable bit is set again.
- R3: A write to offset 4 ORs the written mask into the enable register and leaves the other enable bits unchanged.
- R4: A write to offset 5 clears the enable bits where the mask holds ones and leaves the other enable bits unchanged.
- R5: Writing a one to bit i of offset 3 clears status bit i unless a new event for input i arrives in the same cycle. Writing 0xFFFFFFFF acknowledges every input.
- R6: An input whose bit in `EDGE_MASK` is 1 is edge mode. Its status bit sets one clock after a rising edge is sampled and holds until acknowledged. A rising edge in the same cycle as an acknowledge of that bit leaves the bit set.
- R7: An input whose bit in `EDGE_MASK` is 0 is level mode. Its status bit sets one clock after the line is sampled high. An acknowledge does not clear it while the line is high. After the line falls, the bit stays set until an acknowledge.
- R8: Offset 1 reads as status AND enable.
- R9: Offset 6 reads as the lowest index i whose pending bit is set, zero-extended to 32 bits. It reads as 0xFFFFFFFF when nothing is pending.
- R10: Offset 7 holds two bits, [0] master enable and [1] hardware request enable, and its upper bits read as zero. `irq_o` is high exactly when both bits are 1 and at least one pending bit is set.
- R11: After reset, status, enable and master control are zero, the vector reads 0xFFFFFFFF and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines, one per input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences first separate the two input modes. A pulse on an edge input must stay latched after the line drops. A held level input must survive an acknowledge and clear only after it falls. Enable writes through the replace, set and clear aliases check that neighbouring bits do not move. Several inputs pending at once check that the vector follows the lowest enabled index when a lower input is masked. A rising edge that coincides with its own acknowledge checks that the new event wins. A long random phase, with random lines and random writes to every offset, is compared on every clock against a behavioural model of the status, enable and master state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned OFS_W = 3;

    // Word offsets; software decodes these, so the order is fixed.
    typedef enum logic [OFS_W-1:0] {
        OFS_STATUS = 3'd0,
        OFS_PEND   = 3'd1,
        OFS_ENABLE = 3'd2,
        OFS_ACK    = 3'd3,
        OFS_SETEN  = 3'd4,
        OFS_CLREN  = 3'd5,
        OFS_VECTOR = 3'd6,
        OFS_MASTER = 3'd7
    } reg_ofs_e;

    localparam logic [1:0] MASTER_ON = 2'b11;

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int unsigned           NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0]    EDGE_SEL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] status_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] line;
        logic [NUM_SRC-1:0] status;
    } cap_t;

    cap_t               cap_d, cap_q;
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        if (EDGE_SEL[g]) begin : g_edge
            assign hit[g] = src_i[g] & ~cap_q.line[g];

            a_r6_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
                (src_i[g] && !cap_q.line[g]) |=> status_o[g]);
        end else begin : g_level
            assign hit[g] = src_i[g];

            a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
                src_i[g] |=> status_o[g]);
        end

        a_r5_hold_unacked: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[g] && !ack_i[g]) |=> status_o[g]);
    end

    always_comb begin
        cap_d        = cap_q;
        cap_d.line   = src_i;
        cap_d.status = hit | (cap_q.status & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign status_o = cap_q.status;

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
    parameter  int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_SRC-1:0] below_mask;

    // Fixed priority: the lowest index wins, so scan downwards and keep the last hit.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    assign below_mask = (NUM_SRC'(1) << idx_o) - NUM_SRC'(1);

    always_comb begin
        a_r9_lowest_pending: assert (!hit_o || (pend_i[idx_o] && ((pend_i & below_mask) == '0)));
        a_r9_idle_none: assert (hit_o || (pend_i == '0));
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic [1:0]         master;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] pend;
    logic               vec_hit;
    logic [IDX_W-1:0]   vec_idx;

    assign wmask = reg_wdata[NUM_SRC-1:0];
    assign ack   = (reg_wr && reg_addr == OFS_ACK) ? wmask : '0;

    irqc_capture #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_SEL (EDGE_MASK[NUM_SRC-1:0])
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .ack_i    (ack),
        .status_o (status)
    );

    assign pend = status & ctl_q.enable;

    irqc_vector #(
        .NUM_SRC (NUM_SRC)
    ) u_vector (
        .pend_i (pend),
        .hit_o  (vec_hit),
        .idx_o  (vec_idx)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            case (reg_addr)
                OFS_ENABLE: ctl_d.enable = wmask;
                OFS_SETEN:  ctl_d.enable = ctl_q.enable | wmask;
                OFS_CLREN:  ctl_d.enable = ctl_q.enable & ~wmask;
                OFS_MASTER: ctl_d.master = reg_wdata[1:0];
                default:    ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_o = (ctl_q.master == MASTER_ON) && (|pend);

    always_comb begin
        case (reg_addr)
            OFS_STATUS: reg_rdata = REG_W'(status);
            OFS_PEND:   reg_rdata = REG_W'(pend);
            OFS_ENABLE: reg_rdata = REG_W'(ctl_q.enable);
            OFS_VECTOR: reg_rdata = vec_hit ? REG_W'(vec_idx) : '1;
            OFS_MASTER: reg_rdata = REG_W'(ctl_q.master);
            default:    reg_rdata = '0;
        endcase
    end

    a_r3_set_merges: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_SETEN) |=>
        ((ctl_q.enable & $past(wmask)) == $past(wmask)) &&
        ((ctl_q.enable & ~$past(wmask)) == ($past(ctl_q.enable) & ~$past(wmask))));

    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CLREN) |=>
        ((ctl_q.enable & $past(wmask)) == '0) &&
        ((ctl_q.enable & ~$past(wmask)) == ($past(ctl_q.enable) & ~$past(wmask))));

    a_r2_zero_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ENABLE && wmask == '0) |=> !irq_o);

    a_r10_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_MASTER && reg_wdata[1:0] != MASTER_ON) |=> !irq_o);

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;

    localparam int unsigned NUM_SRC = 32;
    localparam logic [31:0] EDGE    = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    bit [31:0] m_status, m_en, m_prev;
    bit [1:0]  m_master;

    always #5 clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_read(input logic [2:0] a);
        bit [31:0] p;
        p = m_status & m_en;
        case (a)
            3'd0: return m_status;
            3'd1: return p;
            3'd2: return m_en;
            3'd6: begin
                for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
                return 32'hFFFF_FFFF;
            end
            3'd7: return {30'b0, m_master};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R6 status";
            3'd1: return "R8 pending";
            3'd2: return "R2 enable";
            3'd6: return "R9 vector";
            3'd7: return "R10 master";
            default: return "R1 zero-read";
        endcase
    endfunction

    // Behavioural model, stepped on every rising edge.
    always @(posedge clk) begin : model
        bit [31:0] ackm, rise;
        if (!rst_n) begin
            m_status = '0; m_en = '0; m_master = '0; m_prev = '0;
        end else begin
            ackm = (reg_wr && reg_addr == 3'd3) ? reg_wdata : 32'h0;
            rise = src_i & ~m_prev;
            m_status = (m_status & ~ackm) | (rise & EDGE) | (src_i & ~EDGE);
            if (reg_wr) begin
                if (reg_addr == 3'd2) m_en = reg_wdata;
                if (reg_addr == 3'd4) m_en = m_en | reg_wdata;
                if (reg_addr == 3'd5) m_en = m_en & ~reg_wdata;
                if (reg_addr == 3'd7) m_master = reg_wdata[1:0];
            end
            m_prev = src_i;
        end
    end

    // Per-cycle comparison, sampled away from the edge.
    always @(posedge clk) begin
        #2;
        if (cmp_on && !done) begin
            chk("R10 irq", {31'b0, irq_o},
                {31'b0, (m_master == 2'b11) && ((m_status & m_en) != 0)});
            chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        @(negedge clk);
        #1;
        chk(tag, {31'b0, irq_o}, {31'b0, exp});
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R11 reset state
        peek(3'd6, 32'hFFFF_FFFF, "R11 vector idle");
        peek(3'd0, 32'h0, "R11 status");
        peek(3'd2, 32'h0, "R11 enable");
        irq_is(1'b0, "R11 irq");

        wr(3'd7, 32'h3);
        peek(3'd7, 32'h3, "R10 master on");
        wr(3'd2, 32'h0001_0005);
        peek(3'd2, 32'h0001_0005, "R2 replace");
        wr(3'd4, 32'h0000_0010);
        peek(3'd2, 32'h0001_0015, "R3 set-enable");
        wr(3'd5, 32'h0000_0001);
        peek(3'd2, 32'h0001_0014, "R4 clear-enable");

        // R6 edge input pulse latches
        set_src(32'h4);
        peek(3'd0, 32'h4, "R6 edge latched");
        set_src(32'h0);
        peek(3'd0, 32'h4, "R6 edge held");
        peek(3'd1, 32'h4, "R8 pending");
        peek(3'd6, 32'd2, "R9 vector");
        irq_is(1'b1, "R10 irq high");

        // R5 acknowledge
        wr(3'd3, 32'h4);
        peek(3'd0, 32'h0, "R5 ack clears");
        peek(3'd6, 32'hFFFF_FFFF, "R9 idle after ack");
        irq_is(1'b0, "R5 irq low after ack");

        // R7 level input
        set_src(32'h0001_0000);
        peek(3'd0, 32'h0001_0000, "R7 level latched");
        wr(3'd3, 32'h0001_0000);
        peek(3'd0, 32'h0001_0000, "R7 ack ignored while high");
        set_src(32'h0);
        peek(3'd0, 32'h0001_0000, "R7 held after fall");
        wr(3'd3, 32'h0001_0000);
        peek(3'd0, 32'h0, "R7 ack after fall");

        // R9 priority among several
        set_src(32'h0001_0014);
        peek(3'd6, 32'd2, "R9 lowest of three");
        wr(3'd5, 32'h4);
        peek(3'd6, 32'd4, "R9 masked lower skipped");
        peek(3'd1, 32'h0001_0010, "R8 pending masked");
        peek(3'd0, 32'h0001_0014, "R8 status unmasked");

        // R10 master bits
        wr(3'd7, 32'h1);
        irq_is(1'b0, "R10 only bit0");
        wr(3'd7, 32'h2);
        irq_is(1'b0, "R10 only bit1");
        wr(3'd7, 32'hFFFF_FFFF);
        peek(3'd7, 32'h3, "R10 upper bits zero");
        irq_is(1'b1, "R10 both bits");

        // R2 zero enable masks all
        wr(3'd2, 32'h0);
        irq_is(1'b0, "R2 zero enable");
        peek(3'd1, 32'h0, "R2 pending masked");

        // R1 ignored writes and zero reads
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        peek(3'd0, 32'h0001_0014, "R1 status unchanged");
        peek(3'd2, 32'h0, "R1 enable unchanged");
        peek(3'd3, 32'h0, "R1 ack reads zero");
        peek(3'd4, 32'h0, "R1 set reads zero");
        peek(3'd5, 32'h0, "R1 clear reads zero");

        // R5 ack all, then R6 edge and ack in the same cycle
        set_src(32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        peek(3'd0, 32'h0, "R5 ack all");
        @(negedge clk);
        src_i = 32'h100; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h100;
        @(negedge clk);
        reg_wr = 1'b0;
        peek(3'd0, 32'h100, "R6 edge beats ack");

        // Random phase, compared every clock
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            src_i     = $urandom;
            reg_wr    = ($urandom % 3) == 0;
            reg_addr  = 3'($urandom);
            reg_wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
        end
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule